// File: doc/BRIEF.md
# PS/2 Host Frame Receiver

This block sits on the host side of a PS/2 link and turns the device-to-host bit stream into bytes. The open-drain clock and data lines arrive already conditioned at pad level. Inside the block they pass through a two-flop synchronizer. The data line is then sampled on every qualified falling edge of the link clock. Each frame has eleven bits: a low start bit, eight data bits with the least significant bit first, an odd-parity bit and a high stop bit. A good frame yields one byte on `rx_byte` together with a single-cycle `rx_valid` strobe and a parity-error flag.

Each falling edge is qualified by its spacing from the last accepted edge. The spacing is measured in microseconds by a prescaler that counts system clocks. An edge that comes too soon after the last accepted edge is treated as a glitch and dropped. An edge that comes after too long a silence in the middle of a frame means an edge was lost, so the partial frame is thrown away. Edges that come shortly after the host has finished its own transmission are also dropped.

A framing or timing fault raises `resend_req` for one cycle. The host transmitter uses this request to send the resend command, whose code is on `resend_cmd`. When the host transmit path is disabled, the block treats a parity fault as a frame fault. It also keeps the device's acknowledge and not-acknowledge bytes from reaching the consumer in that case.

Top module: `ps2_frame_rx`

## Requirements
- R1: A frame is sampled on falling link-clock edges: a start bit of 0, data bits with the least significant bit first, a parity bit and a stop bit of 1. After the stop bit, `rx_byte` carries the byte and `rx_valid` is high for exactly one cycle. These outputs change on the third rising system-clock edge after the falling edge reaches the input pins.
- R2: The parity is odd: the parity bit plus the ones in the data byte give an odd total. A frame with correct parity is delivered with `rx_parity_err` = 0.
- R3: A falling edge that comes less than MIN_GAP_US microseconds after the last accepted edge is ignored. It neither advances the frame nor causes an output.
- R4: A start bit of 1 or a stop bit of 0 discards the frame, delivers no byte and pulses `resend_req` for one cycle. The next falling edge is then taken as a new start bit.
- R5: With `tx_enable` = 1, a parity mismatch still delivers the byte, with `rx_parity_err` = 1 in the same cycle as `rx_valid`.
- R6: With `tx_enable` = 0, a parity mismatch discards the frame and pulses `resend_req`.
- R7: A falling edge can come more than MAX_GAP_US microseconds after the last accepted edge while a frame is partly received. That edge aborts the frame and pulses `resend_req`, and it is not taken as a start bit.
- R8: Falling edges that come less than MIN_GAP_US microseconds after a `tx_done` pulse are ignored.
- R9: With `tx_enable` = 0, a received 0xFE is discarded with a `resend_req` pulse. A received 0xFA is discarded silently, and the next frame is received normally. With `tx_enable` = 1, both codes are delivered.
- R10: After reset, `rx_valid` = 0, `resend_req` = 0 and `rx_byte` = 0x00. `resend_cmd` always reads 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Link clock line as seen at the pad (asynchronous) |
| ps2_data_in | input | 1 | Link data line as seen at the pad (asynchronous) |
| tx_enable | input | 1 | Host transmit path enabled; selects parity and acknowledge-code handling |
| tx_done | input | 1 | One-cycle pulse when a host-to-device transmission has completed |
| rx_byte | output | 8 | Last delivered data byte |
| rx_valid | output | 1 | One-cycle strobe that `rx_byte` holds a new byte |
| rx_parity_err | output | 1 | Parity mismatch on the byte strobed by `rx_valid` |
| resend_req | output | 1 | One-cycle request to transmit the resend command |
| resend_cmd | output | 8 | Command code to send on a resend request (0xFE) |

## Verification
Every result of this block is due on the third rising system-clock edge after a falling link-clock edge is driven: two synchronizer stages, then one output register. The bench drives the link lines on falling system-clock edges. When it drives a line it works out the outcome from the frame rules and queues it with a due cycle of the drive cycle plus three. On every falling system-clock edge it compares `rx_valid`, `resend_req`, `rx_byte` and `rx_parity_err` with either the queued event for that cycle or the idle value. Edge spacings in the stimulus stay far from the MIN_GAP_US and MAX_GAP_US boundaries, so whole-microsecond rounding in the timers cannot change any outcome.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [7:0] CODE_RESEND = 8'hFE;
    localparam logic [7:0] CODE_ACK    = 8'hFA;

    // slot indices inside a frame
    localparam logic [CNT_W-1:0] SLOT_START  = CNT_W'(0);
    localparam logic [CNT_W-1:0] SLOT_LAST_D = CNT_W'(8);
    localparam logic [CNT_W-1:0] SLOT_PARITY = CNT_W'(9);
    localparam logic [CNT_W-1:0] SLOT_STOP   = CNT_W'(10);

    typedef struct packed {
        logic [CNT_W-1:0] slot;
        logic [7:0]       shreg;
        logic             par_bad;
        logic [7:0]       byte_out;
        logic             valid;
        logic             perr_out;
        logic             resend;
        logic             clk_prev;
    } rx_state_t;

endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_in;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '1;   // idle link lines are high
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ps2_us_timer.sv
module ps2_us_timer #(
    parameter int CLKS_PER_US = 50,
    parameter int LIMIT_US    = 121,
    parameter int CW          = $clog2(LIMIT_US + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] elapsed_us
);

    localparam int PW = $clog2(CLKS_PER_US + 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [CW-1:0] us;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.pre = '0;
            tmr_d.us  = '0;
        end else if (tmr_q.pre == PW'(CLKS_PER_US - 1)) begin
            tmr_d.pre = '0;
            if (tmr_q.us != CW'(LIMIT_US)) tmr_d.us = tmr_q.us + 1'b1;
        end else begin
            tmr_d.pre = tmr_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.pre <= '0;
            tmr_q.us  <= CW'(LIMIT_US);   // start saturated: long ago
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign elapsed_us = tmr_q.us;

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_rx_pkg::*;
#(
    parameter int CLKS_PER_US = 50,
    parameter int MIN_GAP_US  = 40,
    parameter int MAX_GAP_US  = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_in,
    input  logic       ps2_data_in,
    input  logic       tx_enable,
    input  logic       tx_done,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_parity_err,
    output logic       resend_req,
    output logic [7:0] resend_cmd
);

    localparam int GAP_LIMIT = MAX_GAP_US + 1;
    localparam int GW        = $clog2(GAP_LIMIT + 1);
    localparam int TW        = $clog2(MIN_GAP_US + 1);

    logic [1:0]    sync_lines;
    logic          line_clk, line_data;
    logic [GW-1:0] gap_us;
    logic [TW-1:0] tx_us;
    logic          fall_edge, accept, too_soon, overdue, tx_quiet;
    rx_state_t     st_d, st_q;

    ps2_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ps2_data_in, ps2_clk_in}),
        .sync_out (sync_lines)
    );

    assign line_clk  = sync_lines[0];
    assign line_data = sync_lines[1];

    // time since last accepted edge, saturating just above the abort limit
    ps2_us_timer #(.CLKS_PER_US(CLKS_PER_US), .LIMIT_US(GAP_LIMIT), .CW(GW)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .elapsed_us (gap_us)
    );

    // time since the host finished transmitting
    ps2_us_timer #(.CLKS_PER_US(CLKS_PER_US), .LIMIT_US(MIN_GAP_US), .CW(TW)) u_txq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (tx_done),
        .elapsed_us (tx_us)
    );

    assign fall_edge = st_q.clk_prev & ~line_clk;
    assign tx_quiet  = tx_us < TW'(MIN_GAP_US);
    assign overdue   = (gap_us > GW'(MAX_GAP_US)) && (st_q.slot != SLOT_START);
    assign too_soon  = gap_us < GW'(MIN_GAP_US);
    assign accept    = fall_edge && !tx_quiet && !overdue && !too_soon;

    always_comb begin
        logic fault;
        fault         = 1'b0;
        st_d          = st_q;
        st_d.clk_prev = line_clk;
        st_d.valid    = 1'b0;
        st_d.perr_out = 1'b0;
        st_d.resend   = 1'b0;

        if (fall_edge && !tx_quiet && overdue) begin
            fault = 1'b1;
        end else if (accept) begin
            if (st_q.slot == SLOT_START) begin
                if (line_data) begin
                    fault = 1'b1;
                end else begin
                    st_d.slot    = st_q.slot + 1'b1;
                    st_d.shreg   = '0;
                    st_d.par_bad = 1'b0;
                end
            end else if (st_q.slot <= SLOT_LAST_D) begin
                st_d.shreg = {line_data, st_q.shreg[7:1]};
                st_d.slot  = st_q.slot + 1'b1;
            end else if (st_q.slot == SLOT_PARITY) begin
                if (!(^st_q.shreg ^ line_data)) begin
                    if (!tx_enable) fault = 1'b1;
                    else            st_d.par_bad = 1'b1;
                end
                st_d.slot = st_q.slot + 1'b1;
            end else if (st_q.slot == SLOT_STOP) begin
                if (!line_data) begin
                    fault = 1'b1;
                end else if (!tx_enable && st_q.shreg == CODE_RESEND) begin
                    fault = 1'b1;
                end else if (!tx_enable && st_q.shreg == CODE_ACK) begin
                    st_d.slot  = SLOT_START;
                    st_d.shreg = '0;
                end else begin
                    st_d.byte_out = st_q.shreg;
                    st_d.valid    = 1'b1;
                    st_d.perr_out = st_q.par_bad;
                    st_d.slot     = SLOT_START;
                    st_d.shreg    = '0;
                end
            end else begin
                fault = 1'b1;   // out of range slot: resynchronise
            end
        end

        if (fault) begin
            st_d.slot    = SLOT_START;
            st_d.shreg   = '0;
            st_d.par_bad = 1'b0;
            st_d.resend  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.clk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_byte       = st_q.byte_out;
    assign rx_valid      = st_q.valid;
    assign rx_parity_err = st_q.perr_out;
    assign resend_req    = st_q.resend;
    assign resend_cmd    = CODE_RESEND;

endmodule

// File: rtl/ps2_frame_rx_checker.sv
module ps2_frame_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_enable,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_parity_err,
    input logic       resend_req,
    input logic       edge_fall
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);  // R1

    AST_RESEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |=> !resend_req);  // R4

    AST_VALID_OR_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && resend_req));  // R4

    AST_EVENT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || resend_req) |-> $past(edge_fall));  // R3

    AST_PERR_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_parity_err) |-> $past(tx_enable));  // R5

    AST_NO_ACK_CODES_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(tx_enable)) |-> (rx_byte != 8'hFE && rx_byte != 8'hFA));  // R9

endmodule

bind ps2_frame_rx ps2_frame_rx_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_enable     (tx_enable),
    .rx_byte       (rx_byte),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .resend_req    (resend_req),
    .edge_fall     (fall_edge)
);

// File: tb/ps2_frame_rx_test.sv
`timescale 1ns/1ps
module ps2_frame_rx_test;

    localparam int CPU     = 2;
    localparam int MIN_GAP = 40;
    localparam int MAX_GAP = 120;
    localparam int LIMIT   = 150000;

    typedef struct {
        int       due;
        bit       valid;
        bit [7:0] data;
        bit       perr;
        bit       resend;
        string    tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk_in = 1'b1, ps2_data_in = 1'b1;
    logic       tx_enable = 1'b1, tx_done = 1'b0;
    logic [7:0] rx_byte, resend_cmd;
    logic       rx_valid, rx_parity_err, resend_req;

    int    cyc = 0, n_checks = 0, n_fail = 0;
    bit    finished = 1'b0;
    string cur_tag = "R10";
    exp_t  expq[$];

    // reference state
    int       m_slot = 0, m_last = -1000000, m_txd = -1000000;
    bit [7:0] m_shreg = 0;
    bit       m_pbad = 0;

    always #10 clk = ~clk;   // 50 MHz

    ps2_frame_rx #(.CLKS_PER_US(CPU), .MIN_GAP_US(MIN_GAP), .MAX_GAP_US(MAX_GAP)) uut (
        .clk(clk), .rst_n(rst_n), .ps2_clk_in(ps2_clk_in), .ps2_data_in(ps2_data_in),
        .tx_enable(tx_enable), .tx_done(tx_done), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .resend_req(resend_req), .resend_cmd(resend_cmd)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic push(input bit v, input bit [7:0] d, input bit p, input bit r, input string tag);
        exp_t e;
        e.due = cyc + 3; e.valid = v; e.data = d; e.perr = p; e.resend = r; e.tag = tag;
        expq.push_back(e);
    endtask

    // frame rules applied to one falling edge driven now
    task automatic model_fall(input bit d);
        int gap;
        if ((cyc - m_txd) / CPU < MIN_GAP) return;
        gap = (cyc - m_last) / CPU;
        if (gap > MAX_GAP && m_slot != 0) begin
            m_slot = 0; push(0, 0, 0, 1, cur_tag); return;
        end
        if (gap < MIN_GAP) return;
        m_last = cyc;
        if (m_slot == 0) begin
            if (d) push(0, 0, 0, 1, cur_tag);
            else begin m_slot = 1; m_shreg = 0; m_pbad = 0; end
        end else if (m_slot <= 8) begin
            m_shreg[m_slot-1] = d; m_slot++;
        end else if (m_slot == 9) begin
            bit bad = (($countones(m_shreg) + d) % 2) == 0;
            m_slot++;
            if (bad && !tx_enable) begin m_slot = 0; push(0, 0, 0, 1, cur_tag); end
            else m_pbad = bad;
        end else begin
            m_slot = 0;
            if (!d) push(0, 0, 0, 1, cur_tag);
            else if (!tx_enable && m_shreg == 8'hFE) push(0, 0, 0, 1, cur_tag);
            else if (!tx_enable && m_shreg == 8'hFA) begin end
            else push(1, m_shreg, m_pbad, 0, cur_tag);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic fall(input bit d, input int lo, input int hi);
        ps2_data_in = d;
        ps2_clk_in  = 1'b0;
        model_fall(d);
        wait_us(lo);
        ps2_clk_in = 1'b1;
        wait_us(hi);
    endtask

    task automatic send_frame(input bit [7:0] b, input int nbits, input bit bad_start,
                              input bit flip_par, input bit bad_stop, input int spur_after);
        bit par;
        par = ~(^b) ^ flip_par;
        for (int i = 0; i < nbits; i++) begin
            bit d;
            if (i == 0)      d = bad_start;
            else if (i < 9)  d = b[i-1];
            else if (i == 9) d = par;
            else             d = !bad_stop;
            if (i == spur_after) begin
                fall(d, 10, 10);
                fall(d, 5, 55);
            end else begin
                fall(d, 40, 40);
            end
        end
        ps2_data_in = 1'b1;
        wait_us(200);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // per-cycle comparison against the queued expectation
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            exp_t e;
            e.valid = 0; e.data = 0; e.perr = 0; e.resend = 0; e.tag = cur_tag;
            if (expq.size() > 0 && expq[0].due == cyc) e = expq.pop_front();
            check(rx_valid == e.valid, e.tag, "rx_valid", rx_valid, e.valid);
            check(resend_req == e.resend, e.tag, "resend_req", resend_req, e.resend);
            if (e.valid) begin
                check(rx_byte == e.data, e.tag, "rx_byte", rx_byte, e.data);
                check(rx_parity_err == e.perr, e.tag, "rx_parity_err", rx_parity_err, e.perr);
            end
        end
        if (cyc >= LIMIT && !finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R10";
        check(rx_valid == 0, "R10", "rx_valid after reset", rx_valid, 0);
        check(resend_req == 0, "R10", "resend_req after reset", resend_req, 0);
        check(rx_byte == 8'h00, "R10", "rx_byte after reset", rx_byte, 0);
        check(resend_cmd == 8'hFE, "R10", "resend_cmd", resend_cmd, 8'hFE);
        wait_us(10);

        cur_tag = "R1";
        send_frame(8'h5A, 11, 0, 0, 0, -1);
        send_frame(8'h81, 11, 0, 0, 0, -1);
        cur_tag = "R2";
        send_frame(8'h00, 11, 0, 0, 0, -1);
        send_frame(8'hFF, 11, 0, 0, 0, -1);

        cur_tag = "R5";
        send_frame(8'h3C, 11, 0, 1, 0, -1);
        tx_enable = 1'b0;
        cur_tag = "R6";
        send_frame(8'h3C, 11, 0, 1, 0, -1);
        tx_enable = 1'b1;

        cur_tag = "R4";
        send_frame(8'h00, 1, 1, 0, 0, -1);
        send_frame(8'h77, 11, 0, 0, 1, -1);
        send_frame(8'hA5, 11, 0, 0, 0, -1);

        cur_tag = "R3";
        send_frame(8'h6B, 11, 0, 0, 0, 3);
        send_frame(8'hC3, 11, 0, 0, 0, 0);

        cur_tag = "R7";
        send_frame(8'h55, 4, 0, 0, 0, -1);
        fall(1'b1, 40, 40);
        wait_us(200);
        send_frame(8'h47, 11, 0, 0, 0, -1);

        cur_tag = "R8";
        tx_done = 1'b1;
        m_txd = cyc;
        @(negedge clk);
        tx_done = 1'b0;
        wait_us(15);
        fall(1'b0, 5, 80);
        send_frame(8'h29, 11, 0, 0, 0, -1);

        cur_tag = "R9";
        tx_enable = 1'b0;
        send_frame(8'hFE, 11, 0, 0, 0, -1);
        send_frame(8'hFA, 11, 0, 0, 0, -1);
        send_frame(8'h12, 11, 0, 0, 0, -1);
        tx_enable = 1'b1;
        send_frame(8'hFA, 11, 0, 0, 0, -1);
        send_frame(8'hFE, 11, 0, 0, 0, -1);

        wait_us(20);
        finished = 1'b1;
        check(expq.size() == 0, "R1", "pending expectations", expq.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule